// File: doc/BRIEF.md
# Flash Erase Range Splitter

This block turns one erase request, given as a starting byte offset and a byte count, into a series of erase commands for a downstream flash command engine. It uses 32 KB block erases where the request allows them and 4 KB sector erases for the rest. It keeps exactly one command outstanding. The next command is presented only after the engine reports that the previous one has finished, which means the device is no longer busy.

A request is checked before any command goes out. The offset and the length must both be multiples of 4 KB, and the erased range must fit inside the device. A request that fails either check ends at once with an error. An error reported by the engine stops the sequence, and no further command is issued. A single-cycle completion pulse carries the final status. The number of commands issued is reported alongside it, so the split can be checked against a model.

Top module: `erase_splitter`

## Requirements
- R1: After reset the block is idle: `busy`, `cmd_valid` and `fin_done` are 0 and `cmd_count` is 0.
- R2: A request whose offset or length has any of bits [11:0] set is rejected. `fin_done` rises with `fin_error`=1 in the cycle after `req_start`, and no command is issued.
- R3: A request with offset + length greater than 2^ADDR_W bytes is rejected in the same way. A range ending exactly at the top of the device is accepted.
- R4: A request of length 0 that is otherwise legal completes in the cycle after `req_start`, with `fin_error`=0 and no command.
- R5: If the starting offset has bits [14:0] clear, the block first issues block erases (opcode 0x52) while at least 32 KB remains. The address advances by 32768 after each one.
- R6: Whatever remains after R5 is erased with sector erases (opcode 0x20), with the address advancing by 4096. The same applies to the whole request when the start is not 32 KB aligned. Every address is a multiple of 4096.
- R7: `cmd_valid`, `cmd_opcode` and `cmd_addr` stay unchanged until a cycle where `cmd_done` is sampled high. The next command appears only after that cycle.
- R8: When `cmd_error` is high together with `cmd_done`, the sequence stops. `fin_done` and `fin_error` are 1 in the next cycle, and no further command is issued.
- R9: `cmd_count` is cleared when a request is accepted and rises by one for each completed command, including one that failed.
- R10: `req_start` has no effect while `busy` is 1.
- R11: On success `fin_done` is high for exactly one cycle, in the cycle after the last command completes, with `fin_error`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start a request (sampled when idle) |
| req_offset | input | ADDR_W | Starting byte offset |
| req_length | input | ADDR_W+1 | Byte count |
| busy | output | 1 | A request is in progress |
| cmd_valid | output | 1 | An erase command is presented |
| cmd_opcode | output | 8 | 0x20 sector erase, 0x52 block erase |
| cmd_addr | output | ADDR_W | Byte address of the erase |
| cmd_done | input | 1 | Engine finished the presented command |
| cmd_error | input | 1 | Engine failed the command (valid with cmd_done) |
| fin_done | output | 1 | One-cycle completion pulse |
| fin_error | output | 1 | Final status; 1 means rejected or aborted |
| cmd_count | output | CNT_W | Commands completed in the current request |

## Verification
On every cycle, the assertions check that commands are held stable, that addresses and opcodes are aligned and legal, and that the count steps on each handshake. They also check that an engine error or a misaligned start ends the request in the next cycle and that a running request cannot be restarted. Only the bench scenarios can show that the full sequence of commands matches the request. That covers the switch from block to sector erases, exact-fit and overflowing ranges, zero-length requests, and aborts at arbitrary steps under random engine latency.

// File: rtl/erase_split_pkg.sv
`timescale 1ns/1ps
package erase_split_pkg;
   localparam logic [7:0] OP_SECTOR = 8'h20;
   localparam logic [7:0] OP_BLOCK  = 8'h52;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1
   } split_state_e;
endpackage

// File: rtl/erase_req_check.sv
`timescale 1ns/1ps
module erase_req_check #(
   parameter int ADDR_W    = 24,
   parameter int SECTOR_LG = 12
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic [ADDR_W:0]   length,
   output logic              misaligned,
   output logic              overrange,
   output logic              empty
);
   localparam int SUM_W = ADDR_W + 2;
   localparam logic [SUM_W-1:0] DEV_BYTES = {2'b01, {ADDR_W{1'b0}}};

   logic [SUM_W-1:0] end_addr;

   assign end_addr   = {2'b00, offset} + {1'b0, length};
   assign misaligned = (|offset[SECTOR_LG-1:0]) || (|length[SECTOR_LG-1:0]);
   assign overrange  = end_addr > DEV_BYTES;
   assign empty      = (length == '0);
endmodule

// File: rtl/erase_step_pick.sv
`timescale 1ns/1ps
module erase_step_pick
   import erase_split_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SECTOR_LG = 12,
   parameter int BLOCK_LG  = 15
) (
   input  logic              block_mode,
   input  logic [ADDR_W:0]   remaining,
   output logic [7:0]        opcode,
   output logic [ADDR_W:0]   step
);
   localparam logic [ADDR_W:0] SECTOR_BYTES = (ADDR_W+1)'(1) << SECTOR_LG;
   localparam logic [ADDR_W:0] BLOCK_BYTES  = (ADDR_W+1)'(1) << BLOCK_LG;

   logic use_block;

   assign use_block = block_mode && (remaining >= BLOCK_BYTES);
   assign opcode    = use_block ? OP_BLOCK : OP_SECTOR;
   assign step      = use_block ? BLOCK_BYTES : SECTOR_BYTES;
endmodule

// File: rtl/erase_splitter.sv
`timescale 1ns/1ps
module erase_splitter
   import erase_split_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SECTOR_LG = 12,
   parameter int BLOCK_LG  = 15,
   parameter int CNT_W     = 16,
   parameter int USE_BLOCK = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [ADDR_W:0]   req_length,
   output logic              busy,
   output logic              cmd_valid,
   output logic [7:0]        cmd_opcode,
   output logic [ADDR_W-1:0] cmd_addr,
   input  logic              cmd_done,
   input  logic              cmd_error,
   output logic              fin_done,
   output logic              fin_error,
   output logic [CNT_W-1:0]  cmd_count
);
   localparam int MAX_CMDS_LG = ADDR_W - SECTOR_LG;

   generate
      if (SECTOR_LG < 1 || BLOCK_LG <= SECTOR_LG || BLOCK_LG >= ADDR_W) begin : g_bad_geom
         $error("erase_splitter: need 0 < SECTOR_LG < BLOCK_LG < ADDR_W");
      end
      if (CNT_W <= MAX_CMDS_LG) begin : g_bad_cnt
         $error("erase_splitter: CNT_W too narrow for a full-device request");
      end
   endgenerate

   split_state_e      state;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W:0]   remaining;
   logic              block_mode;
   logic              aligned_start;
   logic              misaligned, overrange, empty;
   logic [7:0]        step_op;
   logic [ADDR_W:0]   step;

   erase_req_check #(.ADDR_W(ADDR_W), .SECTOR_LG(SECTOR_LG)) u_check (
      .offset     (req_offset),
      .length     (req_length),
      .misaligned (misaligned),
      .overrange  (overrange),
      .empty      (empty)
   );

   erase_step_pick #(.ADDR_W(ADDR_W), .SECTOR_LG(SECTOR_LG), .BLOCK_LG(BLOCK_LG)) u_pick (
      .block_mode (block_mode),
      .remaining  (remaining),
      .opcode     (step_op),
      .step       (step)
   );

   generate
      if (USE_BLOCK != 0) begin : g_block_on
         assign aligned_start = ~|req_offset[BLOCK_LG-1:0];
      end else begin : g_block_off
         assign aligned_start = 1'b0;
      end
   endgenerate

   assign busy       = (state != ST_IDLE);
   assign cmd_valid  = (state == ST_ISSUE);
   assign cmd_opcode = step_op;
   assign cmd_addr   = cur_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_addr   <= '0;
         remaining  <= '0;
         block_mode <= 1'b0;
         fin_done   <= 1'b0;
         fin_error  <= 1'b0;
         cmd_count  <= '0;
      end else begin
         fin_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_start) begin
                  cmd_count <= '0;
                  if (misaligned || overrange) begin
                     fin_done  <= 1'b1;
                     fin_error <= 1'b1;
                  end else if (empty) begin
                     fin_done  <= 1'b1;
                     fin_error <= 1'b0;
                  end else begin
                     state      <= ST_ISSUE;
                     cur_addr   <= req_offset;
                     remaining  <= req_length;
                     block_mode <= aligned_start;
                     fin_error  <= 1'b0;
                  end
               end
            end
            ST_ISSUE: begin
               if (cmd_done) begin
                  cmd_count <= cmd_count + 1'b1;
                  if (cmd_error) begin
                     state     <= ST_IDLE;
                     fin_done  <= 1'b1;
                     fin_error <= 1'b1;
                  end else begin
                     cur_addr  <= cur_addr + step[ADDR_W-1:0];
                     remaining <= remaining - step;
                     if (remaining == step) begin
                        state     <= ST_IDLE;
                        fin_done  <= 1'b1;
                        fin_error <= 1'b0;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R7: a presented command is held until the engine completes it
   p_hold_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_opcode));

   // R6: every erase address sits on a sector boundary
   p_sector_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_addr[SECTOR_LG-1:0] == '0);

   // R5: block erases only on block boundaries, and only legal opcodes
   p_block_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_opcode == OP_BLOCK |-> cmd_addr[BLOCK_LG-1:0] == '0);
   p_legal_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_opcode == OP_BLOCK || cmd_opcode == OP_SECTOR));

   // R8: an engine error ends the request in the next cycle
   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_done && cmd_error |=> fin_done && fin_error && !cmd_valid);

   // R9: count steps by one per completion handshake
   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_done |=> cmd_count == $past(cmd_count) + 1'b1);

   // R10: a running request cannot be restarted
   p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !cmd_done |=> busy);

   // R2: misaligned requests are refused at once
   p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && req_start && misaligned |=> fin_done && fin_error && !busy);
endmodule

// File: tb/erase_splitter_test.sv
`timescale 1ns/1ps
module erase_splitter_test;
   localparam int AW = 24;
   localparam int unsigned DEV = 32'd1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_start = 1'b0;
   logic [AW-1:0] req_offset = '0;
   logic [AW:0]   req_length = '0;
   logic          busy, cmd_valid, fin_done, fin_error;
   logic [7:0]    cmd_opcode;
   logic [AW-1:0] cmd_addr;
   logic          cmd_done = 1'b0, cmd_error = 1'b0;
   logic [15:0]   cmd_count;

   int n_chk = 0;
   int n_bad = 0;

   int          exp_n;
   bit          exp_rej;
   logic [7:0]  exp_op [64];
   int unsigned exp_ad [64];

   always #5 clk = ~clk;

   erase_splitter uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_offset(req_offset),
      .req_length(req_length), .busy(busy), .cmd_valid(cmd_valid),
      .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_done(cmd_done),
      .cmd_error(cmd_error), .fin_done(fin_done), .fin_error(fin_error),
      .cmd_count(cmd_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic void build(input int unsigned off, input int unsigned len);
      int unsigned a = off;
      int unsigned r = len;
      exp_n = 0;
      exp_rej = (off % 4096 != 0) || (len % 4096 != 0) || (off + len > DEV);
      if (exp_rej) return;
      if (off % 32768 == 0) begin
         while (r >= 32768) begin
            exp_op[exp_n] = 8'h52; exp_ad[exp_n] = a; exp_n++;
            a += 32768; r -= 32768;
         end
      end
      while (r > 0) begin
         exp_op[exp_n] = 8'h20; exp_ad[exp_n] = a; exp_n++;
         a += 4096; r -= 4096;
      end
   endfunction

   task automatic run_req(input int unsigned off, input int unsigned len,
                          input int err_at, input bit inject);
      int k = 0;
      bit fin = 0;
      bit got_err = 0;
      int cyc = 0;
      int dly;
      int exp_cnt;
      bit exp_err, aborts, mis;
      string st_tag;
      logic [AW-1:0] held;
      build(off, len);
      mis = (off % 4096 != 0) || (len % 4096 != 0);
      aborts = !exp_rej && err_at >= 0 && err_at < exp_n;
      exp_err = exp_rej || aborts;
      exp_cnt = exp_rej ? 0 : (aborts ? err_at + 1 : exp_n);
      st_tag = exp_rej ? (mis ? "R2" : "R3") : (len == 0 ? "R4" : (aborts ? "R8" : "R11"));
      @(negedge clk);
      req_offset = off[AW-1:0];
      req_length = (AW+1)'(len);
      req_start  = 1'b1;
      while (!fin && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         req_start = 1'b0; cmd_done = 1'b0; cmd_error = 1'b0;
         if (fin_done) begin
            fin = 1; got_err = fin_error;
         end else if (cmd_valid) begin
            if (k < exp_n) begin
               chk(cmd_opcode == exp_op[k], exp_op[k] == 8'h52 ? "R5" : "R6", "opcode",
                   cmd_opcode, exp_op[k]);
               chk(cmd_addr == exp_ad[k][AW-1:0], exp_op[k] == 8'h52 ? "R5" : "R6", "address",
                   cmd_addr, exp_ad[k]);
            end else begin
               chk(0, "R8", "command beyond expected sequence", k, exp_n);
            end
            held = cmd_addr;
            dly = int'($urandom % 4);
            if (inject && k == 0) dly = 2;
            for (int i = 0; i < dly; i++) begin
               if (inject && k == 0 && i == 0) begin
                  req_start = 1'b1; req_offset = 24'h000800; req_length = 25'h1000;
               end
               @(negedge clk);
               req_start = 1'b0;
               chk(cmd_valid && cmd_addr == held && !fin_done, "R7", "command held",
                   cmd_addr, held);
            end
            cmd_done = 1'b1;
            cmd_error = (k == err_at);
            k++;
         end
      end
      chk(fin, "R11", "completion seen", fin, 1);
      if (exp_rej || len == 0) chk(cyc == 1, st_tag, "cycles to finish", cyc, 1);
      chk(got_err == exp_err, st_tag, "final status", got_err, exp_err);
      chk(cmd_count == exp_cnt, "R9", "command count", cmd_count, exp_cnt);
      chk(k == exp_cnt, inject ? "R10" : "R9", "commands observed", k, exp_cnt);
      @(negedge clk);
      chk(!fin_done && !busy, "R11", "single-cycle done", fin_done, 0);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !cmd_valid && !fin_done && cmd_count == 0, "R1", "reset state",
          {busy, cmd_valid, fin_done}, 0);

      run_req(0, 104 * 1024, -1, 0);          // R5 then R6 remainder
      run_req(4096, 40 * 1024, -1, 0);        // R6 unaligned start
      run_req(32768, 16 * 1024, -1, 0);       // R6 aligned but short
      run_req(32'h100, 4096, -1, 0);          // R2 offset
      run_req(0, 32'h800, -1, 0);             // R2 length
      run_req(DEV - 8192, 12288, -1, 0);      // R3 overflow
      run_req(DEV - 32768, 32768, -1, 0);     // R3 exact fit
      run_req(8192, 0, -1, 0);                // R4
      run_req(0, 104 * 1024, 1, 0);           // R8 abort mid-sequence
      run_req(4096, 12288, 0, 0);             // R8 abort on first
      run_req(65536, 36 * 1024, -1, 1);       // R10 restart ignored

      for (int t = 0; t < 30; t++) begin
         int unsigned off, len;
         int e;
         off = ($urandom % 4096) * 4096;
         if ($urandom % 2 == 1) off = off & ~32'h7FFF;
         if ($urandom % 8 == 0) off += 512;
         len = ($urandom % 41) * 4096;
         e = ($urandom % 5 == 0) ? int'($urandom % (len / 4096 + 1)) : -1;
         run_req(off, len, e, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule